// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block stands in front of a group of protected control registers and decides whether a write to them may proceed. Software opens the gate by writing two key bytes to a dedicated key address: 0xCA first, then 0x53 as the very next key-address write. After that, writes to the protected registers go through. Any other byte written to the key address, including 0xFF, shuts the gate again at once.

The block sits on a simple register write port made of an address, a data byte and a strobe. It produces a level `unlocked` and one gated write-enable per protected register. A protected write that arrives while the gate is shut drives no enable, so it is dropped without a trace. Reads never pass through this block, so they are never gated. Writes to addresses other than the key address do not disturb an unlock sequence that is in progress.

Top module: `keylock_guard`

## Requirements
- R1: After reset, and whenever reset is asserted, `unlocked` is 0.
- R2: A key-address write of 0xCA, followed by a key-address write of 0x53 as the next key-address write, sets `unlocked` to 1 from the clock edge that takes the second write.
- R3: After 0xCA, a key-address write of any value other than 0xCA or 0x53 abandons the sequence. A later 0x53 then leaves `unlocked` at 0 until a fresh 0xCA has been written.
- R4: Writing 0xCA again while waiting for the second key keeps the block waiting, so a following 0x53 unlocks.
- R5: While unlocked, any key-address write re-locks from the next edge. 0xFF or any other value besides 0xCA returns to the fully locked state. 0xCA re-locks and starts a new sequence that waits for 0x53.
- R6: From the locked state, a key-address write of any value other than 0xCA leaves the block locked, and a following 0x53 does not unlock.
- R7: Writes to any address other than the key address (default 0x09) leave the sequence state unchanged, whether that state is locked, waiting or unlocked.
- R8: `prot_we[i]` is 1 in the same cycle as a write strobe to address PROT_BASE+i (default 0x00..0x04) only while `unlocked` is 1. Otherwise it is 0, and at most one bit is ever set.
- R9: Cycles without a write strobe leave the sequence state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| unlocked | output | 1 | 1 while protected writes are allowed |
| prot_we | output | NUM_PROT | Gated write-enables, one per protected register |

## Verification
The bench starts from each of the three sequence states and writes every byte value to the key address. After each write it probes the resulting state with a trailing 0x53. This catches several faults: a design that unlocks on 0x53 alone, one that keeps waiting after a wrong byte, one that drops back to locked on a repeated 0xCA, and one that stays open after a key write. It also sweeps every non-key address in each state. That catches a design that lets stray writes reset or advance the sequence, or that drives a protected enable while locked or for the wrong register. A final check on idle gaps and on reset in the middle of a sequence catches state that leaks across either of them.

// File: rtl/keylock_guard.sv
module keylock_guard #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PROT  = 5,
  parameter logic [ADDR_W-1:0] PROT_BASE = 8'h00,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h09,
  parameter logic [DATA_W-1:0] KEY_ONE   = 8'hCA,
  parameter logic [DATA_W-1:0] KEY_TWO   = 8'h53
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                unlocked,
  output logic [NUM_PROT-1:0] prot_we
);

  typedef enum logic [1:0] {
    GS_SHUT  = 2'd0,
    GS_ARMED = 2'd1,
    GS_OPEN  = 2'd2
  } gate_state_e;

  gate_state_e state_q, state_d;

  logic key_wr;
  assign key_wr = wr_en && (wr_addr == KEY_ADDR);

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      unique case (state_q)
        GS_SHUT:  state_d = (wr_data == KEY_ONE) ? GS_ARMED : GS_SHUT;
        GS_ARMED: begin
          if (wr_data == KEY_TWO)      state_d = GS_OPEN;
          else if (wr_data == KEY_ONE) state_d = GS_ARMED;
          else                         state_d = GS_SHUT;
        end
        GS_OPEN:  state_d = (wr_data == KEY_ONE) ? GS_ARMED : GS_SHUT;
        default:  state_d = GS_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_SHUT;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == GS_OPEN);

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_gate
    localparam logic [ADDR_W-1:0] SLOT_ADDR = PROT_BASE + ADDR_W'(i);
    assign prot_we[i] = wr_en && unlocked && (wr_addr == SLOT_ADDR);
  end

endmodule

module keylock_guard_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PROT  = 5,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h09,
  parameter logic [DATA_W-1:0] KEY_TWO  = 8'h53
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic                unlocked,
  input logic [NUM_PROT-1:0] prot_we
);

  AST_RESET_SHUT: assert property (@(posedge clk) !rst_n |=> !unlocked); // R1

  AST_OPEN_AFTER_KEY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == KEY_TWO)); // R2

  AST_RELOCK_BY_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(wr_en && wr_addr == KEY_ADDR)); // R5

  AST_OTHER_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != KEY_ADDR) |=> $stable(unlocked)); // R7

  AST_GATE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_we != '0) |-> (unlocked && wr_en)); // R8

  AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_we)); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(unlocked)); // R9

endmodule

bind keylock_guard keylock_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
  .KEY_ADDR(KEY_ADDR), .KEY_TWO(KEY_TWO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .unlocked(unlocked), .prot_we(prot_we)
);

// File: tb/keylock_guard_bench.sv
module keylock_guard_bench;
  localparam logic [7:0] KADDR = 8'h09;
  localparam logic [7:0] K1 = 8'hCA;
  localparam logic [7:0] K2 = 8'h53;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic unlocked;
  logic [NP-1:0] prot_we;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keylock_guard u_keylock_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unlocked(unlocked), .prot_we(prot_we)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic [NP-1:0] pw);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #2 pw = prot_we;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic kw(input logic [7:0] d);
    logic [NP-1:0] pw;
    wr(KADDR, d, pw);
  endtask

  // 0 shut, 1 armed, 2 open
  task automatic goto_state(input int s);
    kw(8'hFF);
    if (s >= 1) kw(K1);
    if (s == 2) kw(K2);
  endtask

  function automatic int model_next(input int s, input logic [7:0] d);
    if (s == 1) return (d == K2) ? 2 : (d == K1) ? 1 : 0;
    return (d == K1) ? 1 : 0;
  endfunction

  function automatic string tag_for(input int s, input logic [7:0] d);
    if (s == 0) return (d == K1) ? "R2" : "R6";
    if (s == 1) return (d == K1) ? "R4" : (d == K2) ? "R2" : "R3";
    return "R5";
  endfunction

  initial begin
    logic [NP-1:0] pw;
    #7 check(unlocked == 1'b0, "R1", unlocked, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(unlocked == 1'b0, "R1", unlocked, 0);

    kw(K1); kw(K2);
    check(unlocked == 1'b1, "R2", unlocked, 1);

    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 256; d++) begin
        int n;
        goto_state(s);
        kw(8'(d));
        n = model_next(s, 8'(d));
        check(unlocked == (n == 2), tag_for(s, 8'(d)), unlocked, int'(n == 2));
        if (n != 2) begin
          kw(K2);
          check(unlocked == (n == 1), tag_for(s, 8'(d)), unlocked, int'(n == 1));
        end
      end
    end

    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 256; a++) begin
        logic [NP-1:0] exp_pw;
        if (a == int'(KADDR)) continue;
        goto_state(s);
        wr(8'(a), (s == 1) ? 8'hFF : K2, pw);
        exp_pw = '0;
        if (s == 2 && a < NP) exp_pw[a] = 1'b1;
        check(pw == exp_pw, "R8", pw, exp_pw);
        check(unlocked == (s == 2), "R7", unlocked, int'(s == 2));
        if (s != 2) begin
          kw(K2);
          check(unlocked == (s == 1), "R7", unlocked, int'(s == 1));
        end
      end
    end

    goto_state(1);
    repeat (6) @(negedge clk);
    kw(K2);
    check(unlocked == 1'b1, "R9", unlocked, 1);
    repeat (6) @(negedge clk);
    check(unlocked == 1'b1, "R9", unlocked, 1);

    goto_state(1);
    @(negedge clk) rst_n = 1'b0;
    #3 check(unlocked == 1'b0, "R1", unlocked, 0);
    @(negedge clk) rst_n = 1'b1;
    kw(K2);
    check(unlocked == 1'b0, "R1", unlocked, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule